// File: doc/BRIEF.md
# Bus Slave Timeout Monitor

This block sits next to an AXI4 slave port that a host reaches through an address window. It watches the read and write transactions that the host issues. When the downstream logic leaves a transaction unfinished for longer than a fixed number of clock cycles, the block counts a timeout.

The block also keeps the address of the first transaction that timed out. It stores that address relative to the window, meaning it zeroes every bit at or above the window size. It then overwrites the two low bits with a code that tells a read from a write. Because the code replaces those two bits, a stored value stands for a 4-byte-aligned address.

Software reads the count and the address through a small register port that answers in the same cycle. A read can optionally clear both values as it returns them. Several instances can guard separate windows. Each instance picks its own address width (32 or 64 bits), its window size and its timeout threshold. The block observes only. It never aborts or completes a transaction that hangs.

Top module: `axi_stall_monitor`

## Requirements
- R1: A read transaction starts at the AR handshake and ends at the handshake of the R beat with `s_rlast` = 1. If that beat is accepted at or before the TMO_CYC-th rising edge after the AR handshake, no timeout is recorded. Otherwise exactly one timeout is recorded, at that TMO_CYC-th edge, whatever happens afterwards.
- R2: A write transaction starts at the first AW or W handshake and ends at the B handshake. The same TMO_CYC rule applies, counted from the starting handshake. The address comes from the AW handshake, even when that handshake follows the W handshake.
- R3: The timeout count rises by the number of transactions that time out in a cycle (1, or 2 when a read and a write time out together). It saturates at 2^CNT_W-1 and does not wrap. CNT_W defaults to 32.
- R4: The address of the first timeout after reset or after a clear is kept. Later timeouts leave it unchanged until the next clear.
- R5: In the stored address, every bit at position WIN_BITS and above reads 0.
- R6: Bits [1:0] of the stored address read 2'b01 for a read timeout and 2'b10 for a write timeout. If the first timeout is a read and a write in the same cycle, the read address is the one stored.
- R7: `rd_data` is combinational from `rd_sel`:
  - `rd_sel` = 0 returns the count, zero-extended to 32 bits.
  - `rd_sel` = 1 returns address bits [31:0].
  - `rd_sel` = 2 returns address bits [63:32].
  - `rd_sel` = 3 returns 0.
- R8: When `rd_en` and `rd_clr` are both 1 at a rising edge, the count and the stored address return to 0 at that edge, and that same cycle's `rd_data` still shows the values from before the clear. `rd_en` with `rd_clr` = 0 changes nothing.
- R9: Priority runs reset, then clear, then increment. When a clear and a timeout meet at the same edge, the count becomes the number of new timeouts and the new timeout's address is stored.
- R10: ADDR_W selects a 32-bit or a 64-bit address path. With ADDR_W = 32, `rd_sel` = 2 reads 0. After reset every readable word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_arvalid | input | 1 | Observed read address valid |
| s_arready | input | 1 | Observed read address ready |
| s_araddr | input | ADDR_W | Observed read address |
| s_rvalid | input | 1 | Observed read data valid |
| s_rready | input | 1 | Observed read data ready |
| s_rlast | input | 1 | Observed last read beat |
| s_awvalid | input | 1 | Observed write address valid |
| s_awready | input | 1 | Observed write address ready |
| s_awaddr | input | ADDR_W | Observed write address |
| s_wvalid | input | 1 | Observed write data valid |
| s_wready | input | 1 | Observed write data ready |
| s_bvalid | input | 1 | Observed write response valid |
| s_bready | input | 1 | Observed write response ready |
| rd_en | input | 1 | Status read strobe |
| rd_clr | input | 1 | Clear the status on this read |
| rd_sel | input | 2 | Status word select |
| rd_data | output | 32 | Selected status word |

## Verification
The assertions take for granted that at most one read and at most one write are in flight at any time. They also assume that a write carries only a single AW handshake. With a second transaction in flight, a start handshake could arrive while its direction is busy. The block ignores such a handshake, so the checks on timeouts per transaction would not hold. The stimulus keeps to these assumptions: each task finishes its response handshake before the next task issues a request, and every write sends exactly one AW beat.

// File: rtl/tmo_mon_pkg.sv
package tmo_mon_pkg;

  typedef enum logic [1:0] {
    TAG_NONE = 2'b00,
    TAG_RD   = 2'b01,
    TAG_WR   = 2'b10
  } tmo_tag_e;

  localparam logic [1:0] SEL_COUNT   = 2'd0;
  localparam logic [1:0] SEL_ADDR_LO = 2'd1;
  localparam logic [1:0] SEL_ADDR_HI = 2'd2;

  // Make an address window-relative, then overwrite bits [1:0] with the direction tag.
  function automatic logic [63:0] rel_addr(input logic [63:0] a,
                                           input int unsigned win,
                                           input tmo_tag_e    tag);
    logic [63:0] mask;
    logic [63:0] r;
    mask   = (win >= 64) ? '1 : ((64'd1 << win) - 64'd1);
    r      = a & mask;
    r[1:0] = tag;
    return r;
  endfunction

endpackage

// File: rtl/txn_watchdog.sv
module txn_watchdog #(
  parameter int ADDR_W  = 32,
  parameter int TMO_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              finish_i,
  output logic              busy_o,
  output logic              expire_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

  logic              busy_q;
  logic              tripped_q;
  logic [TW-1:0]     tmr_q;
  logic [ADDR_W-1:0] addr_q;

  assign expire_o = busy_q & ~tripped_q & ~finish_i & (tmr_q == LAST);
  assign busy_o   = busy_q;
  assign addr_o   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tripped_q <= 1'b0;
      tmr_q     <= '0;
      addr_q    <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q    <= 1'b1;
        tripped_q <= 1'b0;
        tmr_q     <= '0;
        addr_q    <= addr_ld_i ? addr_i : '0;
      end
    end else begin
      if (finish_i) begin
        busy_q <= 1'b0;
      end else if (expire_o) begin
        tripped_q <= 1'b1;
      end else if (!tripped_q) begin
        tmr_q <= tmr_q + 1'b1;
      end
      if (addr_ld_i) addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/tmo_status.sv
module tmo_status
  import tmo_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 32,
  parameter int WIN_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] cap_o,
  output logic              cap_vld_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_d;
  logic [ADDR_W-1:0] cap_q, cap_d;
  logic              vld_q, vld_base, vld_d;
  logic [1:0]        n_evt;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [1:0]       inc);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(inc);
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  always_comb begin
    n_evt    = {1'b0, rd_evt_i} + {1'b0, wr_evt_i};
    cnt_base = clr_i ? '0 : cnt_q;
    vld_base = clr_i ? 1'b0 : vld_q;
    cnt_d    = sat_add(cnt_base, n_evt);
    cap_d    = clr_i ? '0 : cap_q;
    vld_d    = vld_base;
    if (!vld_base && (rd_evt_i || wr_evt_i)) begin
      vld_d = 1'b1;
      if (rd_evt_i) cap_d = ADDR_W'(rel_addr(64'(rd_addr_i), WIN_BITS, TAG_RD));
      else          cap_d = ADDR_W'(rel_addr(64'(wr_addr_i), WIN_BITS, TAG_WR));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      vld_q <= vld_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign cap_vld_o = vld_q;
endmodule

// File: rtl/axi_stall_monitor.sv
module axi_stall_monitor
  import tmo_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 32,
  parameter int WIN_BITS = 16,
  parameter int TMO_CYC  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_arvalid,
  input  logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_rvalid,
  input  logic              s_rready,
  input  logic              s_rlast,
  input  logic              s_awvalid,
  input  logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  input  logic              s_wready,
  input  logic              s_bvalid,
  input  logic              s_bready,
  input  logic              rd_en,
  input  logic              rd_clr,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data
);
  logic ar_hs, r_done, aw_hs, w_hs, b_hs, clr_req;
  logic rd_busy, wr_busy, rd_evt, wr_evt;
  logic [ADDR_W-1:0] rd_addr, wr_addr, cap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cap_vld;
  logic [31:0]       word_lo, word_hi;

  assign ar_hs   = s_arvalid & s_arready;
  assign r_done  = s_rvalid & s_rready & s_rlast;
  assign aw_hs   = s_awvalid & s_awready;
  assign w_hs    = s_wvalid & s_wready;
  assign b_hs    = s_bvalid & s_bready;
  assign clr_req = rd_en & rd_clr;

  txn_watchdog #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) u_rd_wd (
    .clk(clk), .rst_n(rst_n), .start_i(ar_hs), .addr_ld_i(ar_hs),
    .addr_i(s_araddr), .finish_i(r_done), .busy_o(rd_busy),
    .expire_o(rd_evt), .addr_o(rd_addr)
  );

  txn_watchdog #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) u_wr_wd (
    .clk(clk), .rst_n(rst_n), .start_i(aw_hs | w_hs), .addr_ld_i(aw_hs),
    .addr_i(s_awaddr), .finish_i(b_hs), .busy_o(wr_busy),
    .expire_o(wr_evt), .addr_o(wr_addr)
  );

  tmo_status #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_BITS(WIN_BITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .rd_evt_i(rd_evt), .rd_addr_i(rd_addr),
    .wr_evt_i(wr_evt), .wr_addr_i(wr_addr), .clr_i(clr_req),
    .cnt_o(cnt_q), .cap_o(cap_q), .cap_vld_o(cap_vld)
  );

  assign word_lo = cap_q[31:0];

  generate
    if (ADDR_W > 32) begin : g_wide
      logic [63:0] cap64;
      assign cap64   = 64'(cap_q);
      assign word_hi = cap64[63:32];
    end else begin : g_narrow
      assign word_hi = 32'd0;
    end
  endgenerate

  always_comb begin
    unique case (rd_sel)
      SEL_COUNT:   rd_data = 32'(cnt_q);
      SEL_ADDR_LO: rd_data = word_lo;
      SEL_ADDR_HI: rd_data = word_hi;
      default:     rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/stall_monitor_chk.sv
module stall_monitor_chk #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 32,
  parameter int WIN_BITS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic [CNT_W-1:0]  cnt,
  input logic [ADDR_W-1:0] cap,
  input logic              cap_vld
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  logic [CNT_W-1:0] n_new;
  assign n_new = CNT_W'($countones({rd_evt, wr_evt}));

  AST_RD_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt); // R1
  AST_WR_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == MAXV) |=> cnt == MAXV); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !rd_evt && !wr_evt) |=> $stable(cnt)); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (rd_evt || wr_evt) && cnt < MAXV - 1) |=> cnt == $past(cnt) + $past(n_new)); // R3
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && !clr) |=> $stable(cap)); // R4
  AST_WINDOW_REL: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> ((64'(cap) >> WIN_BITS) == 64'd0)); // R5
  AST_TAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> (cap[1:0] == 2'b01 || cap[1:0] == 2'b10)); // R6
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rd_evt && !wr_evt) |=> (cnt == '0 && !cap_vld && cap == '0)); // R8
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (rd_evt || wr_evt)) |=> (cnt == $past(n_new) && cap_vld)); // R9
endmodule

bind axi_stall_monitor stall_monitor_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_BITS(WIN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr_req), .rd_evt(rd_evt), .wr_evt(wr_evt),
  .cnt(cnt_q), .cap(cap_q), .cap_vld(cap_vld)
);

// File: tb/tb_axi_stall_monitor.sv
`timescale 1ns/1ps
module tb_axi_stall_monitor;
  localparam int AW = 64, CW = 4, WB = 36, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arvalid = 0, arready = 0, rvalid = 0, rready = 0, rlast = 0;
  logic awvalid = 0, awready = 0, wvalid = 0, wready = 0, bvalid = 0, bready = 0;
  logic [AW-1:0] araddr = '0, awaddr = '0;
  logic rd_en = 0, rd_clr = 0;
  logic [1:0] rd_sel = 2'd0;
  logic [31:0] rd_data;
  int n_chk = 0, n_fail = 0;

  // Read address: window bits kept (0x5_1234_5677), bits [1:0] -> 01
  localparam logic [63:0] A_RD = 64'hFFFF_FFA5_1234_5677;
  // Write address: window bits kept (0x3_8765_4321), bits [1:0] -> 10
  localparam logic [63:0] A_WR = 64'h0000_0013_8765_4321;

  always #4 clk = ~clk;

  axi_stall_monitor #(.ADDR_W(AW), .CNT_W(CW), .WIN_BITS(WB), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rlast(rlast),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready),
    .s_bvalid(bvalid), .s_bready(bready),
    .rd_en(rd_en), .rd_clr(rd_clr), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic tick; @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic peek(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic expect_state(input string req, input logic [31:0] c,
                              input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] v;
    peek(2'd0, v); check({req, " count"}, v, c);
    peek(2'd1, v); check({req, " addr_lo"}, v, lo);
    peek(2'd2, v); check({req, " addr_hi"}, v, hi);
  endtask

  task automatic run_read(input logic [63:0] a, input int k);
    tick; arvalid = 1; arready = 1; araddr = a;
    tick; arvalid = 0; arready = 0;
    repeat (k - 1) tick;
    rvalid = 1; rready = 1; rlast = 1;
    tick; rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic run_write(input logic [63:0] a, input int k, input bit wfirst);
    tick;
    wvalid = 1; wready = 1;
    if (!wfirst) begin awvalid = 1; awready = 1; awaddr = a; end
    tick; wvalid = 0; wready = 0; awvalid = 0; awready = 0;
    if (wfirst) begin
      awvalid = 1; awready = 1; awaddr = a;
      tick; awvalid = 0; awready = 0;
      repeat (k - 2) tick;
    end else repeat (k - 1) tick;
    bvalid = 1; bready = 1;
    tick; bvalid = 0; bready = 0;
  endtask

  task automatic do_clear;
    tick; rd_en = 1; rd_clr = 1; rd_sel = 2'd0;
    tick; rd_en = 0; rd_clr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    expect_state("R10 reset", 0, 0, 0);
    peek(2'd3, v); check("R7 unused select", v, 0);
  endtask

  task automatic t_read_window;
    run_read(A_RD, TMO);
    expect_state("R1 read done at limit", 0, 0, 0);
    run_read(A_RD, TMO + 1);
    expect_state("R1 R5 R6 read timeout", 1, 32'h1234_5675, 32'h5);
  endtask

  task automatic t_write_keep;
    run_write(A_WR, TMO + 1, 1'b0);
    expect_state("R2 R4 write timeout keeps first", 2, 32'h1234_5675, 32'h5);
    run_write(A_WR, TMO, 1'b1);
    expect_state("R2 write done at limit", 2, 32'h1234_5675, 32'h5);
  endtask

  task automatic t_clear_on_read;
    logic [31:0] v;
    tick; rd_en = 1; rd_clr = 0; rd_sel = 2'd0; #1;
    check("R7 count read", rd_data, 2);
    tick; rd_en = 0;
    expect_state("R8 plain read no effect", 2, 32'h1234_5675, 32'h5);
    tick; rd_en = 1; rd_clr = 1; rd_sel = 2'd1; #1;
    check("R8 clearing read returns old", rd_data, 32'h1234_5675);
    tick; rd_en = 0; rd_clr = 0;
    expect_state("R8 after clear", 0, 0, 0);
    v = 0;
  endtask

  task automatic t_write_first;
    run_write(A_WR, TMO + 1, 1'b1);
    expect_state("R2 R6 W-first write timeout", 1, 32'h8765_4322, 32'h3);
  endtask

  task automatic t_both;
    do_clear;
    tick;
    arvalid = 1; arready = 1; araddr = A_RD;
    awvalid = 1; awready = 1; awaddr = A_WR; wvalid = 1; wready = 1;
    tick;
    arvalid = 0; arready = 0; awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    repeat (20) tick;
    rvalid = 1; rready = 1; rlast = 1; bvalid = 1; bready = 1;
    tick;
    rvalid = 0; rready = 0; rlast = 0; bvalid = 0; bready = 0;
    expect_state("R3 R6 dual timeout read wins", 2, 32'h1234_5675, 32'h5);
  endtask

  task automatic t_clear_meets_event;
    tick; awvalid = 1; awready = 1; awaddr = A_WR; wvalid = 1; wready = 1;
    tick; awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    repeat (15) tick;
    rd_en = 1; rd_clr = 1; rd_sel = 2'd0;
    tick; rd_en = 0; rd_clr = 0;
    bvalid = 1; bready = 1;
    tick; bvalid = 0; bready = 0;
    expect_state("R9 clear with event", 1, 32'h8765_4322, 32'h3);
  endtask

  task automatic t_reset_priority;
    tick; rst_n = 0; rd_en = 1; rd_clr = 1;
    tick; rst_n = 1; rd_en = 0; rd_clr = 0;
    expect_state("R9 reset", 0, 0, 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 17; i++) run_read(A_RD, TMO + 3);
    expect_state("R3 saturation", 15, 32'h1234_5675, 32'h5);
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    t_reset();
    t_read_window();
    t_write_keep();
    t_clear_on_read();
    t_write_first();
    t_both();
    t_clear_meets_event();
    t_reset_priority();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule